// File: doc/BRIEF.md
# Byte-Wide Harvard Processor Core

This block is a small single-issue processor with an 8-bit datapath. It has four general registers and an 8-bit program counter. Each clock cycle it takes one instruction byte from a separate read-only program store, addressed by the program counter, and completes that instruction in the same cycle. Reads from the data store are combinational, and a store writes on the closing clock edge. Arithmetic, compare and immediate results go to register 0 (the accumulator). Increment, decrement, move and load write the register named in the instruction.

The core is meant to sit between two byte-wide memories. The program memory returns the byte at `imem_addr`, and the data memory returns the byte at `dmem_addr`, both within the same cycle. A halt instruction stops the core until the next reset. A flat debug bus shows all four registers at all times, so a system can watch execution without extra ports.

Top module: `byte_cpu`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, the program counter, all four registers and `halted` are zero. `dbg_regs` carries register k in bits 8k+7:8k.
- R2: An instruction byte holds its opcode in bits 7:4, a first register field A in bits 3:2 and a second register field B in bits 1:0 (codes 0..3 select r0..r3). Opcode 1 writes A+B to r0 and opcode 2 writes A-B to r0, both modulo 256.
- R3: Opcode 3 writes 1 to r0 when A > B and 0 otherwise. Opcode 4 writes 1 when A < B and 0 otherwise. Both comparisons are unsigned.
- R4: Opcode 5 increments and opcode 6 decrements the register named by A, in place, modulo 256.
- R5: Opcode 7 sign-extends its 4-bit immediate (bits 3:0). Values 0..7 shift r0 left by that amount. Values 8..15 shift r0 right logically by 16 minus the value, so 8 gives a result of zero.
- R6: Opcode 8 writes r0 AND the zero-extended immediate to r0. Opcode 9 loads the zero-extended immediate into r0.
- R7: Opcode 10 copies register B into register A. Opcode 11 writes the data memory byte at the address held in register B into register A, in the same cycle.
- R8: Opcode 12 drives `dmem_we` high for exactly that cycle, with `dmem_addr` equal to register B and `dmem_wdata` equal to register A. It changes no register.
- R9: Opcode 13 sets the program counter to the zero-extended immediate.
- R10: Opcode 14 sets the PC to its own address plus register A (modulo 256) when register B is zero. Otherwise the PC advances by one.
- R11: Opcode 15 sets the PC to register A when register B is zero. Otherwise the PC advances by one.
- R12: Opcode 0 raises `halted` on the next edge. From then until reset, the PC and registers do not change and `dmem_we` stays low.
- R13: Every other instruction advances the PC by one, and the PC wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| imem_addr | output | 8 | Program memory address (the program counter) |
| imem_data | input | 8 | Instruction byte at `imem_addr` |
| dmem_addr | output | 8 | Data memory address (register B) |
| dmem_wdata | output | 8 | Store data (register A) |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_rdata | input | 8 | Data memory byte at `dmem_addr`, combinational |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_regs | output | 32 | Register k in bits 8k+7:8k |

## Verification
The data memory outputs (`dmem_addr`, `dmem_wdata`, `dmem_we`) follow the current instruction combinationally, so the bench checks them in the same cycle the instruction is presented. Register results, the new program counter and `halted` appear one rising edge after the instruction is presented. The bench samples all outputs on the falling edge. At each falling edge it first compares the memory strobes against the reference model's current state. It then advances the model by one instruction, and compares the registers, PC and halt flag at the next falling edge, after exactly one rising edge has passed.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  typedef enum logic [3:0] {
    OP_HALT = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_GT  = 4'h3,
    OP_LT   = 4'h4, OP_INC = 4'h5, OP_DEC = 4'h6, OP_SHF = 4'h7,
    OP_ANDI = 4'h8, OP_LDI = 4'h9, OP_MOV = 4'hA, OP_LD  = 4'hB,
    OP_ST   = 4'hC, OP_JMP = 4'hD, OP_JRZ = 4'hE, OP_JAZ = 4'hF
  } opc_e;

  typedef enum logic [1:0] {
    PC_STEP, PC_IMM, PC_REL, PC_ABS
  } pcsel_e;

  typedef struct packed {
    opc_e   opc;
    logic   wr_en;
    logic   dst_fld;
    logic   mem_we;
    logic   halt;
    pcsel_e pc_sel;
  } ctl_t;

endpackage

// File: rtl/cpu_decode.sv
module cpu_decode
  import cpu_pkg::*;
(
  input  logic [7:0] instr,
  output ctl_t       ctl
);

  always_comb begin
    ctl         = '0;
    ctl.opc     = opc_e'(instr[7:4]);
    ctl.pc_sel  = PC_STEP;
    unique case (opc_e'(instr[7:4]))
      OP_HALT:                                 ctl.halt = 1'b1;
      OP_ADD, OP_SUB, OP_GT, OP_LT,
      OP_SHF, OP_ANDI, OP_LDI:                 ctl.wr_en = 1'b1;
      OP_INC, OP_DEC, OP_MOV, OP_LD: begin
        ctl.wr_en   = 1'b1;
        ctl.dst_fld = 1'b1;
      end
      OP_ST:                                   ctl.mem_we = 1'b1;
      OP_JMP:                                  ctl.pc_sel = PC_IMM;
      OP_JRZ:                                  ctl.pc_sel = PC_REL;
      OP_JAZ:                                  ctl.pc_sel = PC_ABS;
      default: ;
    endcase
  end

endmodule

// File: rtl/cpu_alu.sv
module cpu_alu
  import cpu_pkg::*;
#(
  parameter int XLEN = 8
) (
  input  opc_e            opc,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [XLEN-1:0] acc,
  input  logic [3:0]      imm,
  input  logic [XLEN-1:0] mem_rd,
  output logic [XLEN-1:0] res
);

  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  logic [XLEN-1:0] imm_z;
  logic [3:0]      rmag;
  logic [XLEN-1:0] shf;

  assign imm_z = XLEN'(imm);
  assign rmag  = 4'd0 - imm;

  always_comb begin
    if (!imm[3])
      shf = acc << imm[2:0];
    else if (int'(rmag) >= XLEN)
      shf = '0;
    else
      shf = acc >> rmag;
  end

  always_comb begin
    unique case (opc)
      OP_ADD:  res = opa + opb;
      OP_SUB:  res = opa - opb;
      OP_GT:   res = (opa > opb) ? ONE : '0;
      OP_LT:   res = (opa < opb) ? ONE : '0;
      OP_INC:  res = opa + ONE;
      OP_DEC:  res = opa - ONE;
      OP_SHF:  res = shf;
      OP_ANDI: res = acc & imm_z;
      OP_LDI:  res = imm_z;
      OP_MOV:  res = opb;
      OP_LD:   res = mem_rd;
      default: res = '0;
    endcase
  end

  // R3
  always_comb begin
    if (opc == OP_GT || opc == OP_LT)
      cmp_bool_chk: assert (res == '0 || res == ONE);
  end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int XLEN = 8,
  parameter int NREG = 4,
  localparam int RSEL = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RSEL-1:0]      wr_sel,
  input  logic [XLEN-1:0]      wr_data,
  input  logic [RSEL-1:0]      rd_sel_a,
  input  logic [RSEL-1:0]      rd_sel_b,
  output logic [XLEN-1:0]      rd_a,
  output logic [XLEN-1:0]      rd_b,
  output logic [XLEN-1:0]      rd_acc,
  output logic [NREG*XLEN-1:0] dbg
);

  logic [XLEN-1:0] q   [NREG];
  logic [NREG-1:0] en;

  always_comb begin
    for (int i = 0; i < NREG; i++)
      en[i] = wr_en && (wr_sel == RSEL'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (en[i]) q[i] <= wr_data;
    end
  end

  assign rd_a   = q[rd_sel_a];
  assign rd_b   = q[rd_sel_b];
  assign rd_acc = q[0];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign dbg[g*XLEN +: XLEN] = q[g];

    // R4
    reg_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == RSEL'(g)) |=> dbg[g*XLEN +: XLEN] == $past(wr_data));

    // R8
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_sel == RSEL'(g)) |=> $stable(dbg[g*XLEN +: XLEN]));
  end

endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
  import cpu_pkg::*;
#(
  parameter int XLEN = 8,
  parameter int NREG = 4,
  localparam int RSEL = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [XLEN-1:0]      imem_addr,
  input  logic [7:0]           imem_data,
  output logic [XLEN-1:0]      dmem_addr,
  output logic [XLEN-1:0]      dmem_wdata,
  output logic                 dmem_we,
  input  logic [XLEN-1:0]      dmem_rdata,
  output logic                 halted,
  output logic [NREG*XLEN-1:0] dbg_regs
);

  ctl_t            ctl;
  logic [RSEL-1:0] fld_a, fld_b;
  logic [3:0]      imm;
  logic [XLEN-1:0] val_a, val_b, val_acc, alu_res;
  logic [XLEN-1:0] pc_q, pc_nxt;
  logic            halted_q, halted_nxt;
  logic            run, pc_en, b_zero;

  assign fld_a = imem_data[3:2];
  assign fld_b = imem_data[1:0];
  assign imm   = imem_data[3:0];
  assign run   = !halted_q;

  cpu_decode u_dec (
    .instr (imem_data),
    .ctl   (ctl)
  );

  cpu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl.wr_en && run),
    .wr_sel   (ctl.dst_fld ? fld_a : '0),
    .wr_data  (alu_res),
    .rd_sel_a (fld_a),
    .rd_sel_b (fld_b),
    .rd_a     (val_a),
    .rd_b     (val_b),
    .rd_acc   (val_acc),
    .dbg      (dbg_regs)
  );

  cpu_alu #(.XLEN(XLEN)) u_alu (
    .opc    (ctl.opc),
    .opa    (val_a),
    .opb    (val_b),
    .acc    (val_acc),
    .imm    (imm),
    .mem_rd (dmem_rdata),
    .res    (alu_res)
  );

  assign b_zero = (val_b == '0);

  // next-state: program counter and halt flag
  always_comb begin
    unique case (ctl.pc_sel)
      PC_IMM:  pc_nxt = XLEN'(imm);
      PC_REL:  pc_nxt = b_zero ? pc_q + val_a : pc_q + XLEN'(1);
      PC_ABS:  pc_nxt = b_zero ? val_a        : pc_q + XLEN'(1);
      default: pc_nxt = pc_q + XLEN'(1);
    endcase
    pc_en      = run && !ctl.halt;
    halted_nxt = halted_q || ctl.halt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else begin
      if (pc_en) pc_q     <= pc_nxt;
      if (run)   halted_q <= halted_nxt;
    end
  end

  assign imem_addr  = pc_q;
  assign halted     = halted_q;
  assign dmem_addr  = val_b;
  assign dmem_wdata = val_a;
  assign dmem_we    = ctl.mem_we && run;

  // R12
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(imem_addr) && $stable(dbg_regs)));

  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !dmem_we);

  // R12
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && imem_data[7:4] == 4'h0) |=> (halted && $stable(imem_addr)));

  // R9
  jump_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && imem_data[7:4] == 4'hD) |=> imem_addr == XLEN'($past(imem_data[3:0])));

  // R13
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && imem_data[7:4] != 4'h0 && imem_data[7:4] < 4'hD)
      |=> imem_addr == $past(imem_addr) + XLEN'(1));

  // R10
  jrz_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && imem_data[7:4] == 4'hE && dmem_addr != '0)
      |=> imem_addr == $past(imem_addr) + XLEN'(1));

  // R8
  store_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> (imem_data[7:4] == 4'hC && !halted));

endmodule

// File: tb/tb_byte_cpu.sv
`timescale 1ns/1ps
module tb_byte_cpu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, halted;
  logic [31:0] dbg_regs;

  logic [7:0] imem [256];
  logic [7:0] dmem [256];

  int m_pc, m_halt;
  int m_r   [4];
  int m_mem [256];
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  byte_cpu dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .halted(halted), .dbg_regs(dbg_regs)
  );

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(string rq, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic cmp_state(string rq_r, string rq_p);
    chk(rq_p, "pc", int'(imem_addr), m_pc);
    chk(rq_p, "halted", int'(halted), m_halt);
    for (int k = 0; k < 4; k++)
      chk(rq_r, $sformatf("r%0d", k), int'(dbg_regs[k*8 +: 8]), m_r[k]);
  endtask

  // one instruction of the reference model; also checks the memory strobes
  task automatic model_step(output string rq_r, output string rq_p);
    int ins, opc, o1, o2, imm, a, b, npc;
    ins = int'(imem[m_pc]);
    opc = ins >> 4; o1 = (ins >> 2) & 3; o2 = ins & 3; imm = ins & 15;
    a = m_r[o1]; b = m_r[o2];
    npc = (m_pc + 1) & 255;
    rq_p = "R13"; rq_r = "R13";
    if (m_halt != 0) begin
      rq_r = "R12"; rq_p = "R12";
      chk("R12", "dmem_we while halted", int'(dmem_we), 0);
      return;
    end
    chk(opc == 12 ? "R8" : "R12", "dmem_we", int'(dmem_we), opc == 12 ? 1 : 0);
    case (opc)
      0:  begin m_halt = 1; npc = m_pc; rq_r = "R12"; rq_p = "R12"; end
      1:  begin m_r[0] = (a + b) & 255; rq_r = "R2"; end
      2:  begin m_r[0] = (a - b) & 255; rq_r = "R2"; end
      3:  begin m_r[0] = (a > b) ? 1 : 0; rq_r = "R3"; end
      4:  begin m_r[0] = (a < b) ? 1 : 0; rq_r = "R3"; end
      5:  begin m_r[o1] = (a + 1) & 255; rq_r = "R4"; end
      6:  begin m_r[o1] = (a + 255) & 255; rq_r = "R4"; end
      7:  begin
            if (imm < 8) m_r[0] = (m_r[0] << imm) & 255;
            else         m_r[0] = m_r[0] >> (16 - imm);
            rq_r = "R5";
          end
      8:  begin m_r[0] = m_r[0] & imm; rq_r = "R6"; end
      9:  begin m_r[0] = imm; rq_r = "R6"; end
      10: begin m_r[o1] = b; rq_r = "R7"; end
      11: begin
            chk("R7", "load address", int'(dmem_addr), b);
            m_r[o1] = m_mem[b]; rq_r = "R7";
          end
      12: begin
            chk("R8", "store address", int'(dmem_addr), b);
            chk("R8", "store data", int'(dmem_wdata), a);
            m_mem[b] = a; rq_r = "R8";
          end
      13: begin npc = imm; rq_p = "R9"; rq_r = "R9"; end
      14: begin if (b == 0) npc = (m_pc + a) & 255; rq_p = "R10"; rq_r = "R10"; end
      default: begin if (b == 0) npc = a; rq_p = "R11"; rq_r = "R11"; end
    endcase
    m_pc = npc;
  endtask

  task automatic fill_imem(logic [7:0] v);
    for (int i = 0; i < 256; i++) imem[i] = v;
  endtask

  task automatic run_prog(int max_cyc);
    string rq_r, rq_p;
    int tail;
    rst_n = 1'b0;
    m_pc = 0; m_halt = 0;
    for (int k = 0; k < 4; k++) m_r[k] = 0;
    for (int i = 0; i < 256; i++) begin
      dmem[i]  = 8'((i * 37 + 11) & 255);
      m_mem[i] = (i * 37 + 11) & 255;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    cmp_state("R1", "R1");
    rst_n = 1'b1;
    // R1: state right after release, before the first executing edge
    cmp_state("R1", "R1");
    tail = 0;
    for (int n = 0; n < max_cyc && tail < 4; n++) begin
      model_step(rq_r, rq_p);
      if (m_halt != 0) tail++;
      @(negedge clk);
      cmp_state(rq_r, rq_p);
    end
  endtask

  initial begin
    // arithmetic, compares, shifts, immediates, moves, loads, stores (R2..R8)
    fill_imem(8'h00);
    begin
      automatic logic [7:0] p1 [34] = '{
        8'h97, 8'hA4, 8'h9F, 8'h11, 8'h24, 8'h34, 8'h41, 8'h38, 8'h5C, 8'h68,
        8'h62, 8'h91, 8'h77, 8'h7F, 8'h91, 8'h78, 8'h9F, 8'h79, 8'h9F, 8'h73,
        8'h9F, 8'h8A, 8'h95, 8'hAC, 8'h99, 8'hC3, 8'hBB, 8'hB7, 8'hCE, 8'hB2,
        8'h6C, 8'hED, 8'h3B, 8'h4E };
      for (int i = 0; i < 34; i++) imem[i] = p1[i];
    end
    run_prog(200);

    // forward jumps, taken and not taken (R9, R10, R11, R12)
    fill_imem(8'h00);
    begin
      automatic logic [7:0] p2 [15] = '{
        8'h94, 8'hA4, 8'h90, 8'hE4, 8'h00, 8'h00, 8'h00, 8'h92, 8'hE4, 8'h9D,
        8'hA8, 8'h90, 8'hF8, 8'hDF, 8'h00 };
      for (int i = 0; i < 15; i++) imem[i] = p2[i];
    end
    run_prog(200);

    // counted loop with a backward relative jump, exit by absolute jump (R10, R11)
    fill_imem(8'h00);
    begin
      automatic logic [7:0] p3 [12] = '{
        8'h68, 8'h68, 8'h68, 8'h9B, 8'hAC, 8'h93, 8'hA4, 8'h64, 8'hFD, 8'h90,
        8'hE8, 8'h00 };
      for (int i = 0; i < 12; i++) imem[i] = p3[i];
    end
    run_prog(200);

    // straight-line increments past address 255 (R13, R4 wrap)
    fill_imem(8'h5C);
    run_prog(300);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule